// File: doc/BRIEF.md
# Two-Wire Register Bus Slave

This block lets a host on a two-wire serial bus reach a small bank of 8-bit control registers inside the chip. The host sends a device address byte, then a register index, then either one data byte to store or a repeated start and a read address byte. In the read case the slave returns the register contents. Both bus lines are sampled by the system clock through synchronisers. SDA is open drain: the slave only ever pulls the line low.

An active-low enable pin switches the whole interface on or off. While it is high, SDA is left released and the protocol engine stays idle. Two registers are implemented. Index 0x0A holds a three-bit write-window control field in bits 7:5. Index 0x13 holds a read-window enable in bit 7. Every other bit and every other index reads as zero. Each accepted data byte also produces a one-cycle write strobe together with the index and the data, so that logic nearby can snoop the writes.

Top module: `regbus_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. After a start, an address byte of 0x00 (write) or 0x01 (read), sent MSB first, is acknowledged: the slave pulls SDA low for the following SCL pulse.
- R2: An address byte other than 0x00 or 0x01 is not acknowledged. The bytes after it are not acknowledged either, and they change no register, until the next start.
- R3: Writing index 0x0A stores data bits 7:5 in `wwin_cfg[2:0]`. A read of index 0x0A returns that field in bits 7:5 and zero in bits 4:0.
- R4: Writing index 0x13 stores data bit 7 in `rwin_en`. A read of index 0x13 returns that bit in bit 7 and zero in bits 6:0.
- R5: A read transaction (write address, index, repeated start, read address) returns the indexed register MSB first. The slave does not drive SDA during the host's not-acknowledge clock that follows.
- R6: After the acknowledge of a written data byte, `wr_stb` is high for exactly one clock, with `wr_idx` and `wr_dat` giving the index and the data. No other event raises `wr_stb`.
- R7: While `bus_en_n` is high, `sda_oe` stays low and bus traffic changes no register.
- R8: Any index byte is acknowledged. A write to an unmapped index leaves `wwin_cfg` and `rwin_en` unchanged, and a read of that index returns 0x00.
- R9: A stop that arrives before the data byte of a write ends the transaction. No strobe follows and no register changes.
- R10: After reset `sda_oe`, `wr_stb`, `wwin_cfg` and `rwin_en` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en_n | input | 1 | Interface enable, active low |
| scl_i | input | 1 | Serial clock from the host |
| sda_i | input | 1 | Sensed level of the serial data line |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_stb | output | 1 | One-cycle pulse for each accepted data byte |
| wr_idx | output | 8 | Register index of the current transaction |
| wr_dat | output | 8 | Last data byte written |
| wwin_cfg | output | 3 | Write-window control field (index 0x0A, bits 7:5) |
| rwin_en | output | 1 | Read-window enable (index 0x13, bit 7) |

## Verification
The bench builds the block with its default parameters: device address 0, two synchroniser stages, and the two control registers at indices 0x0A and 0x13. With these values every address byte the host can send is either the write code, the read code or a foreign code. The bench uses a bus quarter-period of eight system clocks, which is enough to cover the synchroniser delay. It exercises:
- the masking of unused bits when a register is read back,
- an unmapped index,
- a foreign address,
- a stop before the data byte,
- traffic while the interface is disabled.

// File: rtl/regbus_pkg.sv
// Shared widths and the protocol state encoding of the register bus slave.
// Assumes: one byte of index and one byte of data per transaction.
package regbus_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INDEX,
        ST_INDEX_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_MACK,
        ST_IGNORE
    } bus_state_t;
endpackage

// File: rtl/regbus_sync.sv
// Multi-stage synchroniser for asynchronous bus pins.
// Assumes: STAGES >= 2. The reset value is all ones, which is the idle
// level of the bus and the disabled state of the enable pin.
module regbus_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    // Shift the raw pins through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], d};
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/regbus_edges.sv
// Finds SCL edges and start/stop conditions on the synchronised lines.
// Assumes: both inputs come through synchronisers of equal depth, so the
// relative order of SCL and SDA edges is kept.
module regbus_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d, sda_d;

    // Keep the previous sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/regbus_engine.sv
// Protocol engine: receives the address, index and data bytes, drives the
// acknowledges and serialises read data.
// Assumes: SDA changes only while SCL is low, except for start and stop.
// The slave changes SDA only just after a detected SCL fall.
module regbus_engine
    import regbus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_dis,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              drive_low,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] idx,
    output logic [BYTE_W-1:0] wr_dat
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    bus_state_t        state;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              rd_mode, drv_q, stb_q;

    // Protocol sequencing, shifting and acknowledge drive.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_dis) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            bit_cnt <= '0;
            rd_mode <= 1'b0;
            drv_q   <= 1'b0;
            stb_q   <= 1'b0;
            idx     <= '0;
            wr_dat  <= '0;
        end else begin
            stb_q <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                drv_q   <= 1'b0;
            end else if (stop_det) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                drv_q   <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_INDEX, ST_WDATA: begin
                        if (scl_rise && bit_cnt != FULL) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == FULL) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR) begin
                                if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                    drv_q   <= 1'b1;
                                    rd_mode <= shreg[0];
                                    state   <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else if (state == ST_INDEX) begin
                                drv_q <= 1'b1;
                                state <= ST_INDEX_ACK;
                            end else begin
                                drv_q <= 1'b1;
                                state <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (rd_mode) begin
                                shreg   <= rd_data;
                                drv_q   <= ~rd_data[BYTE_W-1];
                                bit_cnt <= CNT_W'(1);
                                state   <= ST_RDATA;
                            end else begin
                                drv_q <= 1'b0;
                                state <= ST_INDEX;
                            end
                        end
                    end
                    ST_INDEX_ACK: begin
                        if (scl_fall) begin
                            drv_q <= 1'b0;
                            idx   <= shreg;
                            state <= ST_WDATA;
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            drv_q  <= 1'b0;
                            wr_dat <= shreg;
                            stb_q  <= 1'b1;
                            state  <= ST_IGNORE;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bit_cnt == FULL) begin
                                drv_q <= 1'b0;
                                state <= ST_MACK;
                            end else begin
                                drv_q   <= ~shreg[BYTE_W-2];
                                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign drive_low = drv_q;
    assign wr_stb    = stb_q;

    // R6
    stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |=> !stb_q);
    // R7
    dis_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dis |=> (state == ST_IDLE && !drv_q));
    // R5
    mack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MACK) |-> !drv_q);
    // R2
    ignore_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !drv_q);
endmodule

// File: rtl/regbus_regs.sv
// Control register bank: two sparse registers that are written from the
// strobe, plus a read multiplexer that returns zero for unused bits.
// Assumes: the strobe is a single-cycle pulse carrying a stable index and data.
module regbus_regs
    import regbus_pkg::*;
#(
    parameter logic [BYTE_W-1:0] WWIN_IDX = 8'h0A,
    parameter logic [BYTE_W-1:0] RWIN_IDX = 8'h13,
    parameter int                WWIN_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] idx,
    input  logic [BYTE_W-1:0] wr_dat,
    output logic [BYTE_W-1:0] rd_data,
    output logic [WWIN_W-1:0] wwin_cfg,
    output logic              rwin_en
);
    localparam int PAD_W = BYTE_W - WWIN_W;

    // Store the mapped fields on a matching strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wwin_cfg <= '0;
            rwin_en  <= 1'b0;
        end else if (wr_stb) begin
            if (idx == WWIN_IDX) wwin_cfg <= wr_dat[BYTE_W-1:PAD_W];
            if (idx == RWIN_IDX) rwin_en  <= wr_dat[BYTE_W-1];
        end
    end

    // Read multiplexer; unmapped bits and indices give zero.
    always_comb begin
        rd_data = '0;
        if (idx == WWIN_IDX)      rd_data = {wwin_cfg, {PAD_W{1'b0}}};
        else if (idx == RWIN_IDX) rd_data = {rwin_en, {(BYTE_W-1){1'b0}}};
    end

    // R3
    wwin_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(wwin_cfg));
    // R4
    rwin_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(rwin_en));
endmodule

// File: rtl/regbus_slave.sv
// Top level of the register bus slave: synchronisers, edge detection,
// protocol engine and register bank.
// Assumes: the pins are asynchronous to clk, and the system clock runs at
// least eight times faster than SCL.
module regbus_slave
    import regbus_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR    = 7'h00,
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] WWIN_IDX    = 8'h0A,
    parameter logic [BYTE_W-1:0] RWIN_IDX    = 8'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_idx,
    output logic [BYTE_W-1:0] wr_dat,
    output logic [2:0]        wwin_cfg,
    output logic              rwin_en
);
    logic              scl_s, sda_s, dis_s;
    logic              scl_rise, scl_fall, start_det, stop_det;
    logic              drive_low;
    logic [BYTE_W-1:0] rd_data;

    regbus_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({bus_en_n, scl_i, sda_i}),
        .q({dis_s, scl_s, sda_s})
    );

    regbus_edges u_edges (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    regbus_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk(clk), .rst_n(rst_n), .bus_dis(dis_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
        .rd_data(rd_data), .drive_low(drive_low), .wr_stb(wr_stb),
        .idx(wr_idx), .wr_dat(wr_dat)
    );

    regbus_regs #(.WWIN_IDX(WWIN_IDX), .RWIN_IDX(RWIN_IDX), .WWIN_W(3)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .idx(wr_idx),
        .wr_dat(wr_dat), .rd_data(rd_data),
        .wwin_cfg(wwin_cfg), .rwin_en(rwin_en)
    );

    // The raw enable pin gates the driver, so SDA is released at once.
    assign sda_oe = drive_low & ~bus_en_n;
endmodule

// File: tb/regbus_slave_tb.sv
`timescale 1ns/1ps
module regbus_slave_tb;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_en_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, wr_stb, rwin_en;
    logic [7:0] wr_idx, wr_dat;
    logic [2:0] wwin_cfg;
    wire sda_line = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_fail = 0;
    int oe_viol = 0;
    bit stb_prev = 1'b0;
    logic [15:0] exp_q[$];

    always #2 clk = ~clk;

    regbus_slave u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en_n(bus_en_n), .scl_i(scl_m),
        .sda_i(sda_line), .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_idx(wr_idx),
        .wr_dat(wr_dat), .wwin_cfg(wwin_cfg), .rwin_en(rwin_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Monitor: pops expected strobes (R6) and watches for SDA driven while disabled (R7).
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_en_n && sda_oe) oe_viol++;
            if (wr_stb) begin
                if (stb_prev) chk(1'b0, "R6", "strobe longer than one clock", 2, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected strobe idx/dat", {wr_idx, wr_dat}, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk({wr_idx, wr_dat} == e, "R6", "strobe idx/dat", {wr_idx, wr_dat}, e);
                end
            end
            stb_prev <= wr_stb;
        end
    end

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
    endtask

    task automatic m_send(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
        end
        sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
        ack = ~sda_line;
        qwait(); scl_m = 1'b0; qwait();
    endtask

    task automatic m_recv(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
            b[i] = sda_line;
            qwait(); scl_m = 1'b0; qwait();
        end
        sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
        chk(sda_oe == 1'b0, "R5", "slave drives during not-ack", sda_oe, 0);
        qwait(); scl_m = 1'b0; qwait();
    endtask

    task automatic bus_write(input logic [7:0] idx, input logic [7:0] dat, input bit acked);
        bit a0, a1, a2;
        if (acked) exp_q.push_back({idx, dat});
        m_start(); m_send(8'h00, a0); m_send(idx, a1); m_send(dat, a2); m_stop();
        chk(a0 == acked, "R1", "write address ack", a0, acked);
        chk(a1 == acked, "R8", "index ack", a1, acked);
        chk(a2 == acked, "R6", "data ack", a2, acked);
    endtask

    task automatic bus_read(input logic [7:0] idx, output logic [7:0] d);
        bit a0, a1, a2;
        m_start(); m_send(8'h00, a0); m_send(idx, a1);
        m_start(); m_send(8'h01, a2); m_recv(d); m_stop();
        chk(a0 && a1, "R1", "read setup acks", {a0, a1}, 3);
        chk(a2, "R1", "read address ack", a2, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d;
        bit a0, a1, a2;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R10 reset state
        chk(sda_oe == 0 && wr_stb == 0, "R10", "sda_oe/wr_stb after reset", {sda_oe, wr_stb}, 0);
        chk(wwin_cfg == 0 && rwin_en == 0, "R10", "registers after reset", {wwin_cfg, rwin_en}, 0);

        // R3 write-window field, unused bits read back zero
        bus_write(8'h0A, 8'hFF, 1'b1);
        chk(wwin_cfg == 3'b111, "R3", "wwin_cfg after 0xFF", wwin_cfg, 7);
        bus_read(8'h0A, d);
        chk(d == 8'hE0, "R3", "read 0x0A", d, 8'hE0);
        bus_write(8'h0A, 8'h5A, 1'b1);
        chk(wwin_cfg == 3'b010, "R3", "wwin_cfg after 0x5A", wwin_cfg, 2);
        bus_read(8'h0A, d);
        chk(d == 8'h40, "R5", "read 0x0A after 0x5A", d, 8'h40);

        // R4 read-window enable bit
        bus_write(8'h13, 8'hFF, 1'b1);
        chk(rwin_en == 1'b1, "R4", "rwin_en set", rwin_en, 1);
        bus_read(8'h13, d);
        chk(d == 8'h80, "R4", "read 0x13", d, 8'h80);
        bus_write(8'h13, 8'h7F, 1'b1);
        chk(rwin_en == 1'b0, "R4", "rwin_en cleared by 0x7F", rwin_en, 0);
        chk(wwin_cfg == 3'b010, "R4", "wwin_cfg untouched", wwin_cfg, 2);

        // R2 foreign address: no ack, following bytes ignored
        m_start(); m_send(8'h42, a0); m_send(8'h0A, a1); m_send(8'h00, a2); m_stop();
        chk(a0 == 0, "R2", "foreign address ack", a0, 0);
        chk(a1 == 0 && a2 == 0, "R2", "ignored bytes ack", {a1, a2}, 0);
        chk(wwin_cfg == 3'b010, "R2", "wwin_cfg after foreign", wwin_cfg, 2);

        // R8 unmapped index
        bus_write(8'h05, 8'hAA, 1'b1);
        chk(wwin_cfg == 3'b010 && rwin_en == 0, "R8", "regs after unmapped write",
            {wwin_cfg, rwin_en}, 4);
        bus_read(8'h05, d);
        chk(d == 8'h00, "R8", "read unmapped", d, 0);

        // R9 stop before data
        m_start(); m_send(8'h00, a0); m_send(8'h0A, a1); m_stop();
        repeat (20) @(negedge clk);
        chk(wwin_cfg == 3'b010, "R9", "wwin_cfg after early stop", wwin_cfg, 2);
        bus_write(8'h0A, 8'h20, 1'b1);
        chk(wwin_cfg == 3'b001, "R9", "write after early stop", wwin_cfg, 1);

        // R7 disabled interface
        bus_en_n = 1'b1;
        repeat (10) @(negedge clk);
        bus_write(8'h0A, 8'hE0, 1'b0);
        chk(wwin_cfg == 3'b001, "R7", "wwin_cfg while disabled", wwin_cfg, 1);
        bus_en_n = 1'b0;
        repeat (10) @(negedge clk);
        bus_read(8'h0A, d);
        chk(d == 8'h20, "R7", "read after re-enable", d, 8'h20);

        repeat (20) @(negedge clk);
        chk(oe_viol == 0, "R7", "sda_oe cycles while disabled", oe_viol, 0);
        chk(exp_q.size() == 0, "R6", "strobes missing", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule